// File: doc/BRIEF.md
# Video Memory Access Slot Generator

This block marks the video-memory access slots in a scanline that an external transfer can use, whether the transfer comes from the CPU or from DMA. It counts CPU clocks from the horizontal interrupt point. From that count, the current mode (narrow or wide) and whether the line is actively displayed, it works out how many usable slots the line has reached so far. It emits a one-cycle enable on each clock where that count rises, and it also reports the number of usable slots the whole line offers.

On an actively displayed line, only a fixed set of irregularly placed pixel-slot positions is free, and that set depends on the mode. On a blanked line, the free slots are packed densely and spaced evenly along the line. Because the index is always derived from the elapsed clock count, a mode change in the middle of a line takes effect at once, with no replay of history. A queue controller downstream consumes the enables. It can also use the index and the total to work out how long a transfer will take.

Top module: `vram_slot_gen`

## Requirements
- R1: While reset is held and right after it, slot_en is 0, slot_idx is 0 and slot_total is 166, which is the narrow-mode blanked value.
- R2: The elapsed count e becomes 1 on the clock edge that samples line_start high. Each later edge adds 1 to it, until it holds at 488. A new line_start restarts it at any point in the line, and slot_idx then reads 0.
- R3: On a narrow active line the pixel position is p = (e*22965)>>16, where 22965 = floor(171*65536/488)+1. slot_idx is the number of positions in {13,27,42,50,58,74,82,90,106,114,122,138,146,154,169,170} that are less than or equal to p.
- R4: On a wide active line p = (e*28202)>>16, where 28202 = floor(210*65536/488)+1. slot_idx is the number of positions in {23,49,57,65,81,89,97,113,121,129,145,153,161,177,185,193,208,209} that are less than or equal to p.
- R5: On a blanked line slot_idx = (e*K)>>16, with K = floor(B*65536/488)+1 and B = 166 in narrow mode or 204 in wide mode.
- R6: The line is active only when disp_en is 1 and vblank is 0. With the display forced off, or during vertical blank, the blanked spacing applies.
- R7: slot_en is high for exactly one clock each time slot_idx rises above its value from the previous clock under the same mode and active setting. Over a full 488-clock line the pulses add up to slot_total.
- R8: slot_total is 16 for narrow active, 18 for wide active, 166 for narrow blanked and 204 for wide blanked. slot_idx never goes above it.
- R9: wide, disp_en and vblank take effect on the next clock edge. On the clock where a new mode or active setting first applies, slot_idx already equals the new setting's value for the current e, and slot_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Pulse at the horizontal interrupt point |
| wide | input | 1 | 1 selects wide mode, 0 selects narrow mode |
| disp_en | input | 1 | Display enable |
| vblank | input | 1 | Beam is in vertical blank |
| slot_en | output | 1 | One-cycle enable for a usable slot |
| slot_idx | output | 8 | Usable slots reached so far in the line |
| slot_total | output | 8 | Usable slots in the current line |

## Verification
The bench builds the block with its default parameters: a 488-clock line, 16 fractional bits, 171 and 210 pixel slots, and 166 and 204 blanked slots. These values place every listed active position inside the line, including the adjacent final pair (169 and 170 narrow, 208 and 209 wide) that is reached only in the last few clocks. They also let the blanked count end exactly on the line total at the saturation point. The mode-switch and restart scenarios exercise the recompute and restart paths at arbitrary points in the line.

// File: rtl/vram_slot_gen.sv
module vram_slot_gen #(
  parameter int LINE_CLKS    = 488,
  parameter int FRAC         = 16,
  parameter int NARROW_PIX   = 171,
  parameter int WIDE_PIX     = 210,
  parameter int NARROW_BLANK = 166,
  parameter int WIDE_BLANK   = 204,
  parameter int IDX_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             wide,
  input  logic             disp_en,
  input  logic             vblank,
  output logic             slot_en,
  output logic [IDX_W-1:0] slot_idx,
  output logic [IDX_W-1:0] slot_total
);
  localparam int LC_W   = $clog2(LINE_CLKS + 1);
  localparam int PROD_W = LC_W + FRAC + 1;
  localparam int N_ACT  = 16;
  localparam int W_ACT  = 18;
  localparam int NP_RATE = (NARROW_PIX   * (1 << FRAC)) / LINE_CLKS + 1;
  localparam int WP_RATE = (WIDE_PIX     * (1 << FRAC)) / LINE_CLKS + 1;
  localparam int NB_RATE = (NARROW_BLANK * (1 << FRAC)) / LINE_CLKS + 1;
  localparam int WB_RATE = (WIDE_BLANK   * (1 << FRAC)) / LINE_CLKS + 1;

  localparam int NPOS [N_ACT] = '{13, 27, 42, 50, 58, 74, 82, 90,
                                  106, 114, 122, 138, 146, 154, 169, 170};
  localparam int WPOS [W_ACT] = '{23, 49, 57, 65, 81, 89, 97, 113, 121,
                                  129, 145, 153, 161, 177, 185, 193, 208, 209};

  logic [LC_W-1:0]   lc;
  logic              wide_q, act_q, wide_p, act_p;
  logic [IDX_W-1:0]  idx_q, idx_c, pos;
  logic [PROD_W-1:0] step, prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc     <= '0;
      wide_q <= 1'b0;
      act_q  <= 1'b0;
      wide_p <= 1'b0;
      act_p  <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (line_start)
        lc <= LC_W'(1);
      else if (lc != LC_W'(LINE_CLKS))
        lc <= lc + LC_W'(1);
      wide_q <= wide;
      act_q  <= disp_en & ~vblank;
      wide_p <= wide_q;
      act_p  <= act_q;
      idx_q  <= idx_c;
    end
  end

  assign step = act_q ? (wide_q ? PROD_W'(WP_RATE) : PROD_W'(NP_RATE))
                      : (wide_q ? PROD_W'(WB_RATE) : PROD_W'(NB_RATE));
  assign prod = PROD_W'(lc) * step;
  assign pos  = IDX_W'(prod >> FRAC);

  always_comb begin
    idx_c = pos;
    if (act_q) begin
      idx_c = '0;
      if (wide_q) begin
        for (int i = 0; i < W_ACT; i++)
          if (IDX_W'(WPOS[i]) <= pos) idx_c = idx_c + IDX_W'(1);
      end else begin
        for (int i = 0; i < N_ACT; i++)
          if (IDX_W'(NPOS[i]) <= pos) idx_c = idx_c + IDX_W'(1);
      end
    end
  end

  assign slot_idx   = idx_c;
  assign slot_total = act_q ? (wide_q ? IDX_W'(W_ACT) : IDX_W'(N_ACT))
                            : (wide_q ? IDX_W'(WIDE_BLANK) : IDX_W'(NARROW_BLANK));
  assign slot_en    = (idx_c > idx_q) && (wide_q == wide_p) && (act_q == act_p);
endmodule

// File: rtl/vram_slot_gen_chk.sv
module vram_slot_gen_chk #(parameter int IDX_W = 8) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_start,
  input logic             slot_en,
  input logic [IDX_W-1:0] slot_idx,
  input logic [IDX_W-1:0] slot_total
);
  p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en |-> slot_idx == $past(slot_idx) + IDX_W'(1));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en |=> !slot_en);

  p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx <= slot_total);

  p_total_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_total == IDX_W'(16) || slot_total == IDX_W'(18) ||
    slot_total == IDX_W'(166) || slot_total == IDX_W'(204));

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> slot_idx == '0 && !slot_en);
endmodule

bind vram_slot_gen vram_slot_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start),
  .slot_en(slot_en), .slot_idx(slot_idx), .slot_total(slot_total));

// File: tb/vram_slot_gen_test.sv
`timescale 1ns/1ps
module vram_slot_gen_test;
  logic clk = 0, rst_n = 0, line_start = 0, wide = 0, disp_en = 0, vblank = 0;
  logic slot_en;
  logic [7:0] slot_idx, slot_total;
  int n_chk = 0, n_fail = 0;

  int npos [16] = '{13, 27, 42, 50, 58, 74, 82, 90,
                    106, 114, 122, 138, 146, 154, 169, 170};
  int wpos [18] = '{23, 49, 57, 65, 81, 89, 97, 113, 121,
                    129, 145, 153, 161, 177, 185, 193, 208, 209};

  vram_slot_gen uut (.clk(clk), .rst_n(rst_n), .line_start(line_start), .wide(wide),
    .disp_en(disp_en), .vblank(vblank), .slot_en(slot_en), .slot_idx(slot_idx),
    .slot_total(slot_total));

  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_idx(int e, bit w, bit act);
    int n, k, p, c;
    if (act) n = w ? 210 : 171;
    else     n = w ? 204 : 166;
    k = (n * 65536) / 488 + 1;
    p = (e * k) >>> 16;
    if (!act) return p;
    c = 0;
    if (w) begin
      foreach (wpos[i]) if (wpos[i] <= p) c++;
    end else begin
      foreach (npos[i]) if (npos[i] <= p) c++;
    end
    return c;
  endfunction

  function automatic int exp_total(bit w, bit act);
    return act ? (w ? 18 : 16) : (w ? 204 : 166);
  endfunction

  task automatic run_line(string tag, bit w, bit den, bit vb, int sw_at, bit sw_w);
    bit act = den && !vb;
    bit cw = w;
    int prev = 0, pulses = 0, cur;
    bit changed;
    @(negedge clk) begin wide = w; disp_en = den; vblank = vb; end
    @(negedge clk) line_start = 1;
    @(negedge clk) line_start = 0;
    chk({tag, " R8 total"}, slot_total, exp_total(w, act));
    for (int e = 1; e <= 488; e++) begin
      changed = 0;
      if (e == sw_at) begin cw = sw_w; changed = 1; end
      cur = exp_idx(e, cw, act);
      chk({tag, " idx"}, slot_idx, cur);
      chk({tag, " R7 en"}, slot_en, (e > 1 && !changed && cur > prev) ? 1 : 0);
      if (slot_en) pulses++;
      prev = cur;
      if (e + 1 == sw_at) wide = sw_w;
      if (e < 488) @(negedge clk);
    end
    if (sw_at == 0) chk({tag, " R7 pulse count"}, pulses, exp_total(w, act));
    else chk({tag, " R9 total after switch"}, slot_total, exp_total(sw_w, act));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 en", slot_en, 0);
    chk("R1 idx", slot_idx, 0);
    chk("R1 total", slot_total, 166);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R1 idx after release", slot_idx, 0);
    chk("R1 en after release", slot_en, 0);
  endtask

  task automatic t_saturate_restart;
    run_line("R5 narrow blank", 0, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R2 hold idx", slot_idx, 166);
      chk("R2 hold en", slot_en, 0);
    end
    @(negedge clk) begin disp_en = 1; vblank = 0; end
    @(negedge clk) line_start = 1;
    @(negedge clk) line_start = 0;
    for (int e = 1; e < 150; e++) @(negedge clk);
    chk("R2 mid idx", slot_idx, exp_idx(150, 0, 1));
    line_start = 1;
    @(negedge clk) line_start = 0;
    chk("R2 restart idx", slot_idx, 0);
    chk("R2 restart en", slot_en, 0);
    @(negedge clk);
    chk("R2 restart count", slot_idx, exp_idx(2, 0, 1));
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    run_line("R3 narrow active", 0, 1, 0, 0, 0);
    run_line("R4 wide active", 1, 1, 0, 0, 0);
    run_line("R5 wide blank", 1, 1, 1, 0, 0);
    run_line("R6 forced off narrow", 0, 0, 0, 0, 0);
    run_line("R6 forced off wide", 1, 0, 0, 0, 0);
    run_line("R9 narrow to wide", 0, 1, 0, 200, 1);
    run_line("R9 wide to narrow blank", 1, 0, 1, 333, 0);
    t_saturate_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule